// File: doc/BRIEF.md
# Masked latched interrupt controller

This block gathers eight single-bit event sources into sticky interrupt flags and drives one interrupt line towards a host. The sources are hot-plug detect, receiver sense, vertical sync detect, audio FIFO overflow, ITU-656 error, EDID ready, HDCP error and BKSV ready. Any change in a source's level, rising or falling, latches its flag. A flag stays set until the host writes a 1 to its bit.

The flags are split across two 8-bit flag registers. A matching pair of mask registers enables individual flags onto the interrupt line, where a mask bit of 1 lets the flag through. A pair of read-only level registers shows the present, unlatched value of every source. Flags keep latching while masked, so when a mask is enabled later, an event that is already pending drives the interrupt line straight away.

The host reaches all six registers through a simple synchronous read/write port. Reads have a latency of one cycle. The sources are assumed synchronous to `clk`.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, all flags and masks are 0, `irq_o` is 0 and `rd_data_o` is 0.
- R2: A source bit whose level differs from its value at the previous clock edge sets its flag at that edge, for both rising and falling changes. The flag registers are at address 0 and address 1. Address 0 bits 0..3 hold hot-plug, receiver sense, vertical sync and audio FIFO overflow. Address 1 bits 0..3 hold ITU-656 error, EDID ready, HDCP error and BKSV ready. These correspond to `src_i` bits 0..3 and 4..7. Bits 7..4 of every register read as 0.
- R3: A set flag stays set while its source holds steady, until it is cleared.
- R4: Writing a 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R5: When a source change and a write of 1 to the same flag bit fall on the same clock edge, the flag is set after that edge.
- R6: The mask registers are at address 2 (bank 0) and address 3 (bank 1). They are readable and writable in bits 3..0, and a mask bit of 1 enables its flag onto `irq_o`.
- R7: The level registers are at address 4 (bank 0) and address 5 (bank 1). They return the present `src_i` bits with the same bit layout as the flags. Writes to them change no register.
- R8: `irq_o` is registered. It equals the OR over all bits of (flag AND mask) as it stood before the previous clock edge.
- R9: Flags latch whether or not they are masked. Setting a mask bit for a pending flag raises `irq_o` one cycle after the mask write takes effect.
- R10: With `rd_en_i` high, `rd_data_o` takes, at the next edge, the value the addressed register had before that edge. This holds even when a write falls on the same edge. Addresses 6 and above read 0. Without `rd_en_i`, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Event source levels, bit order as in R2 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Single rising and single falling changes of one source show whether a flag responds to both edges and not to a level. A steady source over many cycles shows whether a flag holds. A change on the same edge as a clear of the same bit shows which of the two has priority. A flag raised while its mask is off, with the mask enabled afterwards, tells latching apart from gating at the input. Writes of 0, writes to the level registers and reads of unmapped addresses confirm that these have no effect. A long run of sparse random source toggles, mixed with random reads and writes across the whole address range, is compared every cycle against a behavioural model of flags, masks and read data.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

   // Kind of register selected by an address
   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_FLAG  = 2'd1,
      RK_MASK  = 2'd2,
      RK_LEVEL = 2'd3
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [7:0] bank;
   } reg_sel_t;

   // Flag banks come first, then mask banks, then level banks.
   function automatic reg_sel_t decode_addr(input int unsigned addr,
                                            input int unsigned nbanks);
      reg_sel_t s;
      s.kind = RK_NONE;
      s.bank = '0;
      if (addr < nbanks) begin
         s.kind = RK_FLAG;
         s.bank = 8'(addr);
      end else if (addr < 2 * nbanks) begin
         s.kind = RK_MASK;
         s.bank = 8'(addr - nbanks);
      end else if (addr < 3 * nbanks) begin
         s.kind = RK_LEVEL;
         s.bank = 8'(addr - 2 * nbanks);
      end
      return s;
   endfunction

endpackage

// File: rtl/irq_latch_edge.sv
// Any-change detector: one history register per source.
module irq_latch_edge #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] evt_o
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign evt_o = lvl_i ^ prev_q;

endmodule

// File: rtl/irq_latch_bank.sv
// One bank of sticky flags with its enable mask.
module irq_latch_bank #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_we_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] wr_bits_i,
   output logic [W-1:0] flag_o,
   output logic [W-1:0] mask_o,
   output logic         pend_o
);

   logic [W-1:0] flag_q;
   logic [W-1:0] mask_q;
   logic [W-1:0] clr_bits;

   assign clr_bits = {W{clr_we_i}} & wr_bits_i;

   // Set term is applied after the clear term, so a new event wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_bits) | evt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_we_i) mask_q <= wr_bits_i;
   end

   assign flag_o = flag_q;
   assign mask_o = mask_q;
   assign pend_o = |(flag_q & mask_q);

endmodule

// File: rtl/irq_latch_regport.sv
// Address decode, per-bank write strobes and registered read mux.
module irq_latch_regport #(
   parameter int REG_W        = 8,
   parameter int SRC_PER_BANK = 4,
   parameter int NUM_BANKS    = 2,
   parameter int ADDR_W       = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en_i,
   input  logic                                rd_en_i,
   input  logic [ADDR_W-1:0]                   addr_i,
   input  logic [REG_W-1:0]                    wr_data_i,
   input  logic [SRC_PER_BANK*NUM_BANKS-1:0]   flags_i,
   input  logic [SRC_PER_BANK*NUM_BANKS-1:0]   masks_i,
   input  logic [SRC_PER_BANK*NUM_BANKS-1:0]   levels_i,
   output logic [NUM_BANKS-1:0]                clr_we_o,
   output logic [NUM_BANKS-1:0]                mask_we_o,
   output logic [SRC_PER_BANK-1:0]             wr_bits_o,
   output logic [REG_W-1:0]                    rd_data_o
);
   import irq_latch_pkg::*;

   reg_sel_t         sel;
   logic [REG_W-1:0] flag_w  [NUM_BANKS];
   logic [REG_W-1:0] mask_w  [NUM_BANKS];
   logic [REG_W-1:0] level_w [NUM_BANKS];
   logic [REG_W-1:0] rd_word;
   logic [REG_W-1:0] rd_q;
   logic             data_hi_unused;

   assign sel       = decode_addr(32'(addr_i), 32'(NUM_BANKS));
   assign wr_bits_o = wr_data_i[SRC_PER_BANK-1:0];

   generate
      if (REG_W > SRC_PER_BANK) begin : g_hi
         assign data_hi_unused = ^wr_data_i[REG_W-1:SRC_PER_BANK];
      end else begin : g_nohi
         assign data_hi_unused = 1'b0;
      end

      // Zero-extended register words per bank
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_word
         assign flag_w[b]  = REG_W'(flags_i [b*SRC_PER_BANK +: SRC_PER_BANK]);
         assign mask_w[b]  = REG_W'(masks_i [b*SRC_PER_BANK +: SRC_PER_BANK]);
         assign level_w[b] = REG_W'(levels_i[b*SRC_PER_BANK +: SRC_PER_BANK]);
      end
   endgenerate

   always_comb begin
      clr_we_o  = '0;
      mask_we_o = '0;
      rd_word   = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (sel.bank == 8'(b)) begin
            clr_we_o[b]  = wr_en_i && (sel.kind == RK_FLAG);
            mask_we_o[b] = wr_en_i && (sel.kind == RK_MASK);
            case (sel.kind)
               RK_FLAG:  rd_word = flag_w[b];
               RK_MASK:  rd_word = mask_w[b];
               RK_LEVEL: rd_word = level_w[b];
               default:  rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_en_i) rd_q <= rd_word;
   end

   assign rd_data_o = rd_q;

endmodule

// File: rtl/irq_latch_ctrl.sv
// Masked latched interrupt controller, top level.
module irq_latch_ctrl #(
   parameter int REG_W        = 8,
   parameter int SRC_PER_BANK = 4,
   parameter int NUM_BANKS    = 2,
   parameter int ADDR_W       = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [SRC_PER_BANK*NUM_BANKS-1:0] src_i,
   input  logic                              wr_en_i,
   input  logic                              rd_en_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [REG_W-1:0]                  wr_data_i,
   output logic [REG_W-1:0]                  rd_data_o,
   output logic                              irq_o
);

   localparam int NUM_SRC = SRC_PER_BANK * NUM_BANKS;
   localparam int NUM_REG = 3 * NUM_BANKS;

   // Elaboration-time parameter checks
   generate
      if (SRC_PER_BANK < 1 || SRC_PER_BANK > REG_W) begin : g_bad_spb
         $error("SRC_PER_BANK must be 1..REG_W");
      end
      if (NUM_BANKS < 1 || NUM_BANKS > 255) begin : g_bad_nb
         $error("NUM_BANKS must be 1..255");
      end
      if (NUM_REG > (1 << ADDR_W)) begin : g_bad_aw
         $error("ADDR_W too narrow for the register set");
      end
   endgenerate

   logic [NUM_SRC-1:0]      evt;
   logic [NUM_SRC-1:0]      flag_all;
   logic [NUM_SRC-1:0]      mask_all;
   logic [NUM_BANKS-1:0]    pend;
   logic [NUM_BANKS-1:0]    clr_we;
   logic [NUM_BANKS-1:0]    mask_we;
   logic [SRC_PER_BANK-1:0] wr_bits;
   logic                    irq_q;

   irq_latch_edge #(.W(NUM_SRC)) edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (src_i),
      .evt_o (evt)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         irq_latch_bank #(.W(SRC_PER_BANK)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .clr_we_i  (clr_we[b]),
            .mask_we_i (mask_we[b]),
            .wr_bits_i (wr_bits),
            .flag_o    (flag_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .mask_o    (mask_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .pend_o    (pend[b])
         );
      end
   endgenerate

   irq_latch_regport #(
      .REG_W        (REG_W),
      .SRC_PER_BANK (SRC_PER_BANK),
      .NUM_BANKS    (NUM_BANKS),
      .ADDR_W       (ADDR_W)
   ) port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .rd_en_i   (rd_en_i),
      .addr_i    (addr_i),
      .wr_data_i (wr_data_i),
      .flags_i   (flag_all),
      .masks_i   (mask_all),
      .levels_i  (src_i),
      .clr_we_o  (clr_we),
      .mask_we_o (mask_we),
      .wr_bits_o (wr_bits),
      .rd_data_o (rd_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
// Property checker, bound into irq_latch_ctrl.
module irq_latch_ctrl_chk #(
   parameter int REG_W        = 8,
   parameter int SRC_PER_BANK = 4,
   parameter int NUM_BANKS    = 2,
   parameter int ADDR_W       = 4
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [SRC_PER_BANK*NUM_BANKS-1:0] src_i,
   input logic                              wr_en_i,
   input logic [ADDR_W-1:0]                 addr_i,
   input logic [REG_W-1:0]                  wr_data_i,
   input logic                              irq_o,
   input logic [SRC_PER_BANK*NUM_BANKS-1:0] flags_i,
   input logic [SRC_PER_BANK*NUM_BANKS-1:0] masks_i
);

   localparam int NUM_SRC = SRC_PER_BANK * NUM_BANKS;

   logic               past_ok;
   logic               ok2;
   logic [NUM_SRC-1:0] clr_hit;
   logic [NUM_SRC-1:0] mask_hit;
   logic               chk_hi_unused;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
         ok2     <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         ok2     <= past_ok;
      end
   end

   generate
      if (REG_W > SRC_PER_BANK) begin : g_hi
         assign chk_hi_unused = ^wr_data_i[REG_W-1:SRC_PER_BANK];
      end else begin : g_nohi
         assign chk_hi_unused = 1'b0;
      end
   endgenerate

   // R1: reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (flags_i == '0 && masks_i == '0 && !irq_o)
            else $error("R1 state not clear in reset");
      end
   end

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         localparam int B = i / SRC_PER_BANK;
         localparam int K = i % SRC_PER_BANK;

         assign clr_hit[i]  = wr_en_i && (addr_i == ADDR_W'(B)) && wr_data_i[K];
         assign mask_hit[i] = wr_en_i && (addr_i == ADDR_W'(NUM_BANKS + B));

         // R2 and R5: a source change sets the flag, even against a clear
         a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && (src_i[i] != $past(src_i[i]))) |=> flags_i[i]);

         // R3: a flag only rises after a source change
         a_r3_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flags_i[i]) && ok2) |-> ($past(src_i[i]) != $past(src_i[i], 2)));

         // R4: a flag only falls after a write of 1 to its bit
         a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_i[i]) |-> $past(clr_hit[i]));

         // R6: a mask bit only changes after a write to its mask register
         a_r6_mask_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(masks_i[i]) |-> $past(mask_hit[i]));
      end
   endgenerate

   // R8: interrupt follows enabled pending flags by one cycle
   a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags_i & masks_i)) |=> irq_o);

   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && irq_o) |-> $past(|(flags_i & masks_i)));

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
   .REG_W        (REG_W),
   .SRC_PER_BANK (SRC_PER_BANK),
   .NUM_BANKS    (NUM_BANKS),
   .ADDR_W       (ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_i     (src_i),
   .wr_en_i   (wr_en_i),
   .addr_i    (addr_i),
   .wr_data_i (wr_data_i),
   .irq_o     (irq_o),
   .flags_i   (flag_all),
   .masks_i   (mask_all)
);

// File: tb/irq_latch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb_top;

   localparam int REG_W = 8;
   localparam int SPB   = 4;
   localparam int NB    = 2;
   localparam int AW    = 4;
   localparam int NS    = SPB * NB;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] src;
   logic          wr_en;
   logic          rd_en;
   logic [AW-1:0] addr;
   logic [7:0]    wr_data;
   logic [7:0]    rd_data;
   logic          irq;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   bit cmp_on   = 1'b0;

   always #2.5 clk = ~clk;

   irq_latch_ctrl #(
      .REG_W(REG_W), .SRC_PER_BANK(SPB), .NUM_BANKS(NB), .ADDR_W(AW)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .wr_en_i   (wr_en),
      .rd_en_i   (rd_en),
      .addr_i    (addr),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   // Behavioural reference model, updated at each rising edge
   bit [7:0] m_flag, m_mask, m_prev, m_rd;
   bit       m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flag = '0; m_mask = '0; m_prev = '0; m_rd = '0; m_irq = 1'b0;
      end else begin
         if (rd_en) begin
            case (int'(addr))
               0: m_rd = {4'h0, m_flag[3:0]};
               1: m_rd = {4'h0, m_flag[7:4]};
               2: m_rd = {4'h0, m_mask[3:0]};
               3: m_rd = {4'h0, m_mask[7:4]};
               4: m_rd = {4'h0, src[3:0]};
               5: m_rd = {4'h0, src[7:4]};
               default: m_rd = '0;
            endcase
         end
         m_irq = |(m_flag & m_mask);
         for (int i = 0; i < NS; i++) begin
            automatic int b = i / SPB;
            automatic int k = i % SPB;
            if (src[i] != m_prev[i])                            m_flag[i] = 1'b1;
            else if (wr_en && int'(addr) == b && wr_data[k])    m_flag[i] = 1'b0;
         end
         if (wr_en && int'(addr) == 2) m_mask[3:0] = wr_data[3:0];
         if (wr_en && int'(addr) == 3) m_mask[7:4] = wr_data[3:0];
         m_prev = src;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model (R8 interrupt, R10 read data)
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk("R8 irq vs model", int'(irq), int'(m_irq));
         chk("R10 rd_data vs model", int'(rd_data), int'(m_rd));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; addr = AW'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = int'(rd_data);
   endtask

   initial begin
      int d;
      src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
      rst_n = 1'b0;
      step(4);
      chk("R1 irq in reset", int'(irq), 0);
      chk("R1 rd_data in reset", int'(rd_data), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      step(1);
      rd(0, d); chk("R1 flags bank0 after reset", d, 0);
      rd(2, d); chk("R1 mask bank0 after reset", d, 0);

      // R2: hot-plug rising change
      src[0] = 1'b1; step(1);
      rd(0, d); chk("R2 hot-plug rise sets flag", d, 'h01);
      chk("R9 masked flag keeps irq low", int'(irq), 0);

      // R3: steady source, flag holds
      step(3);
      rd(0, d); chk("R3 flag held", d, 'h01);

      // R4: write of 0 has no effect, write of 1 clears
      wr(0, 'h00);
      rd(0, d); chk("R4 zero write ignored", d, 'h01);
      wr(0, 'h01);
      rd(0, d); chk("R4 one write clears", d, 'h00);

      // R2: hot-plug falling change
      src[0] = 1'b0; step(1);
      rd(0, d); chk("R2 hot-plug fall sets flag", d, 'h01);

      // R6 and R9: enable mask for pending flag
      wr(2, 'hFF);
      rd(2, d); chk("R6 mask bank0 readback", d, 'h0F);
      chk("R9 pending flag exposed on irq", int'(irq), 1);

      // R8: irq is registered, drops one cycle after clear
      wr(0, 'h01);
      chk("R8 irq one cycle after clear", int'(irq), 1);
      step(1);
      chk("R8 irq low after clear", int'(irq), 0);

      // R2: bank1 mapping (EDID ready is src bit 5 -> addr 1 bit 1)
      src[5] = 1'b1; step(1);
      rd(1, d); chk("R2 EDID ready in bank1 bit1", d, 'h02);
      chk("R9 bank1 masked irq low", int'(irq), 0);

      // R5: event and clear on the same edge
      src[6] = 1'b1;
      wr(1, 'h04);
      rd(1, d); chk("R5 event beats clear", d, 'h06);

      // R7: level registers
      rd(5, d); chk("R7 level bank1", d, 'h06);
      rd(4, d); chk("R7 level bank0", d, 'h00);
      wr(5, 'hFF);
      wr(4, 'hFF);
      rd(5, d); chk("R7 level write ignored", d, 'h06);
      rd(0, d); chk("R7 level write leaves flags", d, 'h00);
      rd(3, d); chk("R7 level write leaves masks", d, 'h00);

      // R10: unmapped addresses, hold, read during write
      rd(7, d);  chk("R10 unmapped addr 7", d, 0);
      rd(15, d); chk("R10 unmapped addr 15", d, 0);
      rd(1, d);  chk("R10 read bank1 flags", d, 'h06);
      step(2);
      chk("R10 rd_data holds", int'(rd_data), 'h06);
      wr_en = 1'b1; rd_en = 1'b1; addr = AW'(1); wr_data = 8'h06;
      step(1);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R10 read returns pre-write value", int'(rd_data), 'h06);
      rd(1, d); chk("R10 write landed after read", d, 'h00);

      // R6: bank1 mask upper bits read as 0
      wr(3, 'hF2);
      rd(3, d); chk("R6 mask bank1 readback", d, 'h02);

      // Random phase, compared every cycle against the model
      for (int n = 0; n < 4000; n++) begin
         if ($urandom % 6 == 0) src[$urandom % NS] ^= 1'b1;
         wr_en   = ($urandom % 4 == 0);
         rd_en   = ($urandom % 2 == 0);
         addr    = AW'($urandom % 8);
         wr_data = 8'($urandom);
         step(1);
      end
      wr_en = 1'b0; rd_en = 1'b0;
      step(2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule